// File: doc/BRIEF.md
# Softmax Normalization Stage

This block performs the last two steps of a hardware softmax. Another stage computes the exponentials. This block receives them one per beat for a single region, keeps each value in a small register file and adds it into a running denominator. When the vector closes, it divides every stored value by the denominator. It then emits the normalized probabilities in arrival order over a valid/ready output.

Each probability is an 8-bit fraction. The normalization is selected per vector by a mode input:

- **Exact mode** uses a restoring divider that produces one quotient bit per cycle.
- **Shift mode** replaces the denominator with the power of two nearest to it and right-shifts each numerator. This trades accuracy for a much shorter and cheaper path.

An all-zero vector cannot be normalized. In that case the block returns zeros and raises an error flag alongside each output of that vector.

Top module: `softmax_norm`

## Requirements
- R1: After reset, `inReady` is 1 and `outValid` is 0.
- R2: A vector closes on an accepted beat that has `inLast` set, or on the NUM_CLASS-th accepted beat.
  - From the cycle after the closing beat, `inReady` stays 0 until the final output of that vector is accepted.
  - `inReady` and `outValid` are never high together, and no input offered while busy is taken.
- R3: A closed vector of N values produces exactly N outputs, in the order the values arrived. `outLast` is 1 on the N-th output only, and `inReady` returns the cycle after it is accepted.
- R4: Input codes are 11-bit unsigned with 1 fractional bit. The denominator D is the 13-bit sum of the raw codes.
  - In exact mode, an output is floor(num*256/D) as an 8-bit fraction.
  - When num >= D, the output saturates to 255.
- R5: The denominator saturates at 8191 instead of wrapping.
- R6: In shift mode, let k be the position of the leading one of D.
  - The shift n is k+1 when bit k-1 of D is set, and k otherwise, so ties round up.
  - The output is min(255, floor(num*256 / 2^n)).
- R7: The mode (`shiftMode` = 1 selects shift) is sampled on the closing beat. Changing it while the vector is being emitted has no effect on that vector.
- R8: When D is 0, every output of that vector is 0 with `outErr` = 1. `outErr` is 0 on outputs of vectors with nonzero D.
- R9: While `outValid` is 1 and `outReady` is 0, `outValid`, `outData`, `outLast` and `outErr` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Exponential value offered |
| inReady | output | 1 | Block can take a value |
| inData | input | NUM_W | Exponential code, unsigned, 1 fractional bit |
| inLast | input | 1 | Beat closes the vector |
| shiftMode | input | 1 | 1: power-of-two normalization, 0: exact divide |
| outValid | output | 1 | Probability available |
| outReady | input | 1 | Consumer takes the probability |
| outData | output | OUT_W | Probability, all fractional bits |
| outLast | output | 1 | Final probability of the vector |
| outErr | output | 1 | Vector had a zero denominator |

## Verification
The bench targets four kinds of corner case.

- **Exact-mode saturation.** It sends single-value vectors where the numerator equals the denominator. A divider without the saturation check would wrap to 0 instead of giving 255.
- **Shift-mode rounding.** It sends denominators whose bit below the leading one is set (e.g. 3, 100) and ones where it is clear (5). A rounding slip doubles or halves every output, and a shift below the denominator must clamp rather than overflow.
- **Full and zero vectors.** Full-length vectors of the maximum code catch a wrapping accumulator, which would produce wildly large outputs. All-zero vectors catch a missing guard, which would emit garbage quotients without the error flag.
- **Timing of mode, input and stalls.** The bench flips the mode while outputs drain, offers input while busy, and stalls the consumer at random. These expose a mode read late, a beat taken during emission, or an output that changes under back-pressure.

// File: rtl/smx_pkg.sv
package smx_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic accept;     // store the input beat and add it to the sum
    logic closeVec;   // last beat of the vector: latch the mode
    logic startItem;  // fetch a stored numerator and set up the quotient
    logic divStep;    // one restoring-division step
    logic nextItem;   // advance to the next stored numerator
    logic clearVec;   // final output taken: empty the vector
  } smxCtrlT;

  typedef enum logic [1:0] {
    ST_COLLECT,
    ST_LOAD,
    ST_DIV,
    ST_EMIT
  } smxStateT;

endpackage

// File: rtl/smx_nearest_pow2.sv
module smx_nearest_pow2 #(
  parameter int W = 13,
  localparam int EW = $clog2(W + 1)
) (
  input  logic [W-1:0]  val,
  output logic [EW-1:0] expo
);

  logic [EW-1:0] lead;
  logic          roundUp;

  // Leading-one detector: the highest set bit wins.
  always_comb begin
    lead = '0;
    for (int i = 0; i < W; i++) begin
      if (val[i]) lead = EW'(i);
    end
  end

  // Round to the upper power when the bit just below the leading one is set.
  assign roundUp = (lead != '0) && val[lead - 1'b1];
  assign expo    = lead + EW'(roundUp);

endmodule

// File: rtl/smx_ctrl.sv
module smx_ctrl
  import smx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    inLast,
  input  logic    outReady,
  input  logic    slotFull,
  input  logic    quickDone,
  input  logic    stepsDone,
  input  logic    lastItem,
  output smxCtrlT ctl,
  output logic    inReady,
  output logic    outValid
);

  smxStateT state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_COLLECT;
    else       state <= stateNext;
  end

  always_comb begin
    ctl       = '0;
    stateNext = state;
    unique case (state)
      ST_COLLECT: begin
        if (inValid) begin
          ctl.accept = 1'b1;
          if (inLast || slotFull) begin
            ctl.closeVec = 1'b1;
            stateNext    = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        ctl.startItem = 1'b1;
        stateNext     = quickDone ? ST_EMIT : ST_DIV;
      end
      ST_DIV: begin
        ctl.divStep = 1'b1;
        if (stepsDone) stateNext = ST_EMIT;
      end
      ST_EMIT: begin
        if (outReady) begin
          if (lastItem) begin
            ctl.clearVec = 1'b1;
            stateNext    = ST_COLLECT;
          end else begin
            ctl.nextItem = 1'b1;
            stateNext    = ST_LOAD;
          end
        end
      end
      default: stateNext = ST_COLLECT;
    endcase
  end

  assign inReady  = (state == ST_COLLECT);
  assign outValid = (state == ST_EMIT);

endmodule

// File: rtl/smx_datapath.sv
module smx_datapath
  import smx_pkg::*;
#(
  parameter int NUM_CLASS = 21,
  parameter int NUM_W     = 11,
  parameter int DEN_W     = 13,
  parameter int OUT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  smxCtrlT          ctl,
  input  logic [NUM_W-1:0] inData,
  input  logic             shiftMode,
  output logic             slotFull,
  output logic             lastItem,
  output logic             quickDone,
  output logic             stepsDone,
  output logic             sumZero,
  output logic [OUT_W-1:0] outData
);

  localparam int IDX_W  = $clog2(NUM_CLASS + 1);
  localparam int STEP_W = $clog2(OUT_W);
  localparam int EXP_W  = $clog2(DEN_W + 1);
  localparam int PROD_W = NUM_W + OUT_W;

  logic [NUM_W-1:0]  vals [NUM_CLASS];
  logic [IDX_W-1:0]  wrIdx, rdIdx;
  logic [DEN_W-1:0]  sum, rem;
  logic [OUT_W-1:0]  quo;
  logic [STEP_W-1:0] stepCnt;
  logic              modeShift;

  logic [NUM_W-1:0]  num;
  logic [DEN_W-1:0]  numWide;
  logic [DEN_W:0]    sumWide;
  logic [DEN_W-1:0]  sumSat;
  logic [EXP_W-1:0]  expo;
  logic [PROD_W-1:0] prod, shifted;
  logic [OUT_W-1:0]  shiftQ, quickVal;
  logic [DEN_W:0]    remDbl;
  logic [DEN_W-1:0]  remSub;
  logic              numGeDen, fits;

  // Saturating accumulation of the denominator.
  assign sumWide = {1'b0, sum} + (DEN_W + 1)'(inData);
  assign sumSat  = sumWide[DEN_W] ? '1 : sumWide[DEN_W-1:0];

  assign num      = vals[rdIdx];
  assign numWide  = DEN_W'(num);
  assign numGeDen = numWide >= sum;
  assign sumZero  = (sum == '0);

  smx_nearest_pow2 #(.W(DEN_W)) u_pow2 (
    .val (sum),
    .expo(expo)
  );

  // Shift normalization with clamp at the largest fraction.
  assign prod    = {num, {OUT_W{1'b0}}};
  assign shifted = prod >> expo;
  assign shiftQ  = (|shifted[PROD_W-1:OUT_W]) ? '1 : shifted[OUT_W-1:0];

  assign quickDone = sumZero || modeShift || numGeDen;
  assign quickVal  = sumZero ? '0 : (modeShift ? shiftQ : '1);

  // Restoring division step.
  assign remDbl = {rem, 1'b0};
  assign fits   = remDbl >= {1'b0, sum};
  assign remSub = remDbl[DEN_W-1:0] - sum;

  assign slotFull  = (wrIdx == IDX_W'(NUM_CLASS - 1));
  assign lastItem  = ((rdIdx + 1'b1) == wrIdx);
  assign stepsDone = (stepCnt == STEP_W'(OUT_W - 1));
  assign outData   = quo;

  always_ff @(posedge clk) begin
    if (ctl.accept) vals[wrIdx] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrIdx     <= '0;
      rdIdx     <= '0;
      sum       <= '0;
      rem       <= '0;
      quo       <= '0;
      stepCnt   <= '0;
      modeShift <= 1'b0;
    end else begin
      if (ctl.clearVec) begin
        wrIdx <= '0;
        rdIdx <= '0;
        sum   <= '0;
      end else begin
        if (ctl.accept) begin
          wrIdx <= wrIdx + 1'b1;
          sum   <= sumSat;
        end
        if (ctl.closeVec) modeShift <= shiftMode;
        if (ctl.nextItem) rdIdx <= rdIdx + 1'b1;
      end
      if (ctl.startItem) begin
        stepCnt <= '0;
        rem     <= numWide;
        quo     <= quickDone ? quickVal : '0;
      end
      if (ctl.divStep) begin
        stepCnt <= stepCnt + 1'b1;
        if (fits) begin
          rem <= remSub;
          quo <= {quo[OUT_W-2:0], 1'b1};
        end else begin
          rem <= remDbl[DEN_W-1:0];
          quo <= {quo[OUT_W-2:0], 1'b0};
        end
      end
    end
  end

endmodule

// File: rtl/softmax_norm.sv
module softmax_norm
  import smx_pkg::*;
#(
  parameter int NUM_CLASS = 21,
  parameter int NUM_W     = 11,
  parameter int DEN_W     = 13,
  parameter int OUT_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [NUM_W-1:0] inData,
  input  logic             inLast,
  input  logic             shiftMode,
  output logic             outValid,
  input  logic             outReady,
  output logic [OUT_W-1:0] outData,
  output logic             outLast,
  output logic             outErr
);

  smxCtrlT ctl;
  logic    slotFull, lastItem, quickDone, stepsDone, sumZero;

  smx_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .slotFull (slotFull),
    .quickDone(quickDone),
    .stepsDone(stepsDone),
    .lastItem (lastItem),
    .ctl      (ctl),
    .inReady  (inReady),
    .outValid (outValid)
  );

  smx_datapath #(
    .NUM_CLASS(NUM_CLASS),
    .NUM_W    (NUM_W),
    .DEN_W    (DEN_W),
    .OUT_W    (OUT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .inData   (inData),
    .shiftMode(shiftMode),
    .slotFull (slotFull),
    .lastItem (lastItem),
    .quickDone(quickDone),
    .stepsDone(stepsDone),
    .sumZero  (sumZero),
    .outData  (outData)
  );

  assign outLast = outValid && lastItem;
  assign outErr  = outValid && sumZero;

endmodule

// File: rtl/smx_checker.sv
module smx_checker #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic             inLast,
  input logic             outValid,
  input logic             outReady,
  input logic [OUT_W-1:0] outData,
  input logic             outLast,
  input logic             outErr
);

  assert_close_drops_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady);

  assert_busy_holds_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!inReady && !(outValid && outReady && outLast)) |=> !inReady);

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));

  assert_free_after_last_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && outLast) |=> inReady);

  assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> (outValid && outData == '0));

  assert_stall_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData) && $stable(outLast) && $stable(outErr)));

endmodule

bind softmax_norm smx_checker #(.OUT_W(OUT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .inReady (inReady),
  .inLast  (inLast),
  .outValid(outValid),
  .outReady(outReady),
  .outData (outData),
  .outLast (outLast),
  .outErr  (outErr)
);

// File: tb/tb_softmax_norm.sv
module tb_softmax_norm;
  localparam int C  = 21;
  localparam int NW = 11;
  localparam int OW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0, inValid = 1'b0, inLast = 1'b0, shiftMode = 1'b0, outReady = 1'b1;
  logic [NW-1:0] inData = '0;
  logic          inReady, outValid, outLast, outErr;
  logic [OW-1:0] outData;

  softmax_norm dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inData(inData),
    .inLast(inLast), .shiftMode(shiftMode), .outValid(outValid), .outReady(outReady),
    .outData(outData), .outLast(outLast), .outErr(outErr)
  );

  int    errors = 0, checks = 0;
  string tag = "R1";
  int    expD[$];
  bit    expL[$], expE[$];
  int    pend[$];
  int    accSum = 0;
  bit    busyExp = 0, stallEn = 0, prevStall = 0;
  logic [OW-1:0] prevD;
  logic  prevL, prevE;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int refNorm(input int num, input int den, input bit sh);
    int k, n, q;
    if (den == 0) return 0;
    if (sh) begin
      k = 0;
      for (int b = 0; b < 16; b++) if ((den >> b) & 1) k = b;
      n = k;
      if (k > 0 && ((den >> (k - 1)) & 1)) n = k + 1;
      q = (num * 256) >> n;
    end else begin
      if (num >= den) return 255;
      q = (num * 256) / den;
    end
    return (q > 255) ? 255 : q;
  endfunction

  always @(posedge clk) begin
    #1;
    outReady = stallEn ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  // Behavioural reference model, compared on every falling edge.
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        check(outValid && outData == prevD && outLast == prevL && outErr == prevE, "R9",
              "hold under stall", {outErr, outLast, outData}, {prevE, prevL, prevD});
      if (busyExp)
        check(!inReady, "R2", "inReady while busy", inReady, 0);
      else
        check(inReady && !outValid, "R2", "idle handshake state", {inReady, outValid}, 2);
      if (outValid && expD.size() == 0)
        check(0, "R3", "unexpected output", outData, -1);
      else if (outValid && outReady) begin
        int  d;
        bit  l, e;
        d = expD.pop_front(); l = expL.pop_front(); e = expE.pop_front();
        check({outErr, outLast, outData} == {e, l, d[OW-1:0]}, tag,
              "output value/order/last/err (R3)", {outErr, outLast, outData}, {e, l, d[OW-1:0]});
        if (l) busyExp = 0;
      end
      if (inValid && inReady) begin
        pend.push_back(int'(inData));
        accSum = accSum + int'(inData);
        if (accSum > 8191) accSum = 8191;  // R5 saturation
        if (inLast || pend.size() == C) begin
          for (int i = 0; i < pend.size(); i++) begin
            expD.push_back(refNorm(pend[i], accSum, shiftMode));
            expL.push_back(i == pend.size() - 1);
            expE.push_back(accSum == 0);
          end
          pend.delete();
          accSum  = 0;
          busyExp = 1;
        end
      end
      prevStall = outValid && !outReady;
      prevD = outData; prevL = outLast; prevE = outErr;
    end
  end

  task automatic sendBeat(input int d, input bit last, input bit mode);
    @(posedge clk); #1;
    inValid = 1'b1; inData = NW'(d); inLast = last; shiftMode = mode;
    do @(negedge clk); while (!inReady);
  endtask

  task automatic sendVec(input int v[$], input bit mode, input bit useLast);
    for (int i = 0; i < v.size(); i++) sendBeat(v[i], useLast && (i == v.size() - 1), mode);
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic waitIdle();
    do @(negedge clk); while (busyExp || expD.size() != 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int full[$];
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R1", "reset state", {inReady, outValid}, 2);

    tag = "R4"; sendVec('{10, 20, 30, 40}, 0, 1); waitIdle();   // 25 51 76 102
    tag = "R6"; sendVec('{10, 20, 30, 40}, 1, 1); waitIdle();   // n=7
    tag = "R4"; sendVec('{500}, 0, 1); waitIdle();              // num==den -> 255
    tag = "R6"; sendVec('{3}, 1, 1); sendVec('{5}, 1, 1); waitIdle();  // 192, clamp 255
    tag = "R8"; sendVec('{0, 0, 0}, 0, 1); sendVec('{0, 0}, 1, 1); waitIdle();

    tag = "R5";
    for (int i = 0; i < C; i++) full.push_back(2047);
    sendVec(full, 0, 0); waitIdle();                            // closes on count, 63 each
    sendVec(full, 1, 0); waitIdle();

    tag = "R7"; stallEn = 1;
    sendVec('{100, 7, 900}, 0, 1); shiftMode = 1'b1; waitIdle();
    sendVec('{100, 7, 900}, 1, 1); shiftMode = 1'b0; waitIdle();

    tag = "R3";
    for (int t = 0; t < 8; t++) begin
      int v[$];
      int len;
      len = $urandom_range(1, C);
      for (int i = 0; i < len; i++) v.push_back($urandom_range(0, 2047));
      sendVec(v, 1'($urandom_range(0, 1)), 1);
    end
    waitIdle();

    // R2: input offered while busy must wait for the vector to drain.
    tag = "R2";
    for (int i = 0; i < 2; i++) sendBeat(60, i == 1, 0);
    @(posedge clk); #1;
    inData = NW'(999); inLast = 1'b1;
    do @(negedge clk); while (!inReady);
    @(posedge clk); #1;
    inValid = 1'b0; inLast = 1'b0;
    waitIdle();

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule